// File: doc/BRIEF.md
# Beam Pulse Pattern Generator

This block drives the beam-enable line of one gun channel. A 2-bit beam mode picks one of four patterns. In viewer-limited mode (00), each sync trigger produces a single pulse whose length is set by a 6-bit code. In tune mode (01), each trigger starts a fixed-length frame. The frame holds a short head pulse, a beam-off gap and a marker pulse. The gap and the marker trade length against each other, so their sum never changes. In CW mode (10), beam stays on. In pass/user mode (11), an externally timed gate is passed straight through.

The block counts in ticks of an 8 MHz clock, so one tick is 125 ns. The mode encoding rises in priority from 00 to 11. A fault input drops the output in the same cycle in every mode. Register access, mode arbitration and sync selection belong to the surrounding logic.

Top module: `beam_pattern_gen`

## Requirements
- R1: While `rst` is high, `beam_en` is 0 in every mode, and no sequence is pending once reset is released.
- R2: In mode 00, a rising edge of `sync_in` sampled at a clock edge drives `beam_en` high from the next cycle for exactly 2×`view_code` cycles. A new rising edge during the pulse restarts it at full length. A sync held high gives only one pulse.
- R3: In mode 00, `view_code` 0 gives the same 2-cycle pulse as code 1.
- R4: In mode 01, a rising edge of `sync_in` starts a frame of 2832 cycles from the next cycle. Counting offsets from 0, beam is high at offsets 0 and 1. The marker ends at offset 833. Beam is off for the rest of the frame. With `mark_code` 8, the marker occupies offsets 798 to 833.
- R5: The tune marker lasts 44−`mark_code` cycles and always ends at offset 833, so gap plus marker stays 832 cycles. `mark_code` is captured when the frame starts; later changes do not affect that frame.
- R6: A rising edge of `sync_in` during a running tune frame is ignored. The first edge after the frame ends starts a new frame.
- R7: In mode 10 with no fault, `beam_en` is 1 in every cycle.
- R8: In mode 11 with no fault, `beam_en` equals `ext_gate` in the same cycle.
- R9: While `fault` is high, `beam_en` is 0 in that same cycle in every mode.
- R10: A fault, or a change to another mode, abandons a running viewer-limited pulse or tune frame. Beam does not resume until a new sync edge arrives in the proper mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8 MHz tick clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Beam-sync trigger; its rising edge starts a sequence |
| mode | input | 2 | Beam mode: 00 viewer-limited, 01 tune, 10 CW, 11 pass/user |
| view_code | input | 6 | Viewer-limited pulse length in 250 ns units |
| mark_code | input | 4 | Tune marker shortening in 125 ns units |
| ext_gate | input | 1 | External gate followed in pass/user mode |
| fault | input | 1 | Fault kill; forces beam off |
| beam_en | output | 1 | Gated beam-enable output |

## Verification
The hardest cases sit deep inside a tune frame, thousands of cycles after the trigger. One is a second sync edge arriving while the frame is still running. Another is a fault or a mode change that cuts the frame short. A third is a change to the marker code after the frame has started. The stimulus reaches these by firing a sync, letting the frame run to a chosen offset, and then applying the disturbance. A cycle-by-cycle reference model in the bench predicts the output for every cycle. It predicts that the frame ignores the extra edge, stays dark after the abort until a fresh edge, and keeps the captured marker length.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [1:0] {
        BM_VIEW = 2'b00,
        BM_TUNE = 2'b01,
        BM_CW   = 2'b10,
        BM_PASS = 2'b11
    } beam_mode_e;

    // Tick counts at 125 ns per tick
    localparam int unsigned BP_UNIT_TICKS   = 2;     // 250 ns
    localparam int unsigned BP_HEAD_TICKS   = 2;     // fixed tune head pulse
    localparam int unsigned BP_SPAN_TICKS   = 832;   // gap + marker
    localparam int unsigned BP_MARKER_BASE  = 44;    // marker for code 0
    localparam int unsigned BP_FRAME_TICKS  = 2832;  // whole tune frame

    function automatic int unsigned view_ticks(input int unsigned code,
                                               input int unsigned unit);
        return (code == 0) ? unit : code * unit;
    endfunction

    function automatic int unsigned marker_ticks(input int unsigned base,
                                                 input int unsigned code);
        return base - code;
    endfunction

endpackage

// File: rtl/bp_sync_edge.sv
module bp_sync_edge (
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    output logic rise
);
    logic sync_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 1'b0;
        else     sync_q <= sync_in;
    end

    assign rise = sync_in & ~sync_q;
endmodule

// File: rtl/bp_view_timer.sv
module bp_view_timer #(
    parameter int unsigned CODE_W     = 6,
    parameter int unsigned UNIT_TICKS = bp_pkg::BP_UNIT_TICKS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              start,
    input  logic [CODE_W-1:0] code,
    output logic              beam
);
    localparam int unsigned MAX_LEN = ((1 << CODE_W) - 1) * UNIT_TICKS;
    localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

    logic [CNT_W-1:0] left;
    logic [CNT_W-1:0] load_len;

    always_comb begin
        load_len = CNT_W'(bp_pkg::view_ticks(int'(code), UNIT_TICKS));
    end

    always_ff @(posedge clk) begin
        if (rst || abort)      left <= '0;
        else if (start)        left <= load_len;
        else if (left != '0)   left <= left - 1'b1;
    end

    assign beam = (left != '0);
endmodule

// File: rtl/bp_tune_seq.sv
module bp_tune_seq #(
    parameter int unsigned MK_W        = 4,
    parameter int unsigned HEAD_TICKS  = bp_pkg::BP_HEAD_TICKS,
    parameter int unsigned SPAN_TICKS  = bp_pkg::BP_SPAN_TICKS,
    parameter int unsigned MARKER_BASE = bp_pkg::BP_MARKER_BASE,
    parameter int unsigned FRAME_TICKS = bp_pkg::BP_FRAME_TICKS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            abort,
    input  logic            trigger,
    input  logic [MK_W-1:0] mark_code,
    output logic            beam,
    output logic            busy
);
    localparam int unsigned POS_W    = $clog2(FRAME_TICKS);
    localparam int unsigned ML_W     = $clog2(MARKER_BASE + 1);
    localparam int unsigned MARK_END = HEAD_TICKS + SPAN_TICKS;

    typedef struct packed {
        logic             run;
        logic [POS_W-1:0] pos;
        logic [ML_W-1:0]  mark_len;
    } tune_state_t;

    tune_state_t st;
    logic [POS_W-1:0] mark_start;
    logic             in_head;
    logic             in_mark;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            st <= '0;
        end else if (st.run) begin
            if (st.pos == POS_W'(FRAME_TICKS - 1)) begin
                st.run <= 1'b0;
            end else begin
                st.pos <= st.pos + 1'b1;
            end
        end else if (trigger) begin
            st.run      <= 1'b1;
            st.pos      <= '0;
            st.mark_len <= ML_W'(bp_pkg::marker_ticks(MARKER_BASE, int'(mark_code)));
        end
    end

    always_comb begin
        mark_start = POS_W'(MARK_END) - POS_W'(st.mark_len);
        in_head    = (st.pos < POS_W'(HEAD_TICKS));
        in_mark    = (st.pos >= mark_start) && (st.pos < POS_W'(MARK_END));
    end

    assign beam = st.run && (in_head || in_mark);
    assign busy = st.run;
endmodule

// File: rtl/beam_pattern_gen.sv
module beam_pattern_gen #(
    parameter int unsigned VL_W        = 6,
    parameter int unsigned MK_W        = 4,
    parameter int unsigned UNIT_TICKS  = bp_pkg::BP_UNIT_TICKS,
    parameter int unsigned HEAD_TICKS  = bp_pkg::BP_HEAD_TICKS,
    parameter int unsigned SPAN_TICKS  = bp_pkg::BP_SPAN_TICKS,
    parameter int unsigned MARKER_BASE = bp_pkg::BP_MARKER_BASE,
    parameter int unsigned FRAME_TICKS = bp_pkg::BP_FRAME_TICKS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sync_in,
    input  logic [1:0]      mode,
    input  logic [VL_W-1:0] view_code,
    input  logic [MK_W-1:0] mark_code,
    input  logic            ext_gate,
    input  logic            fault,
    output logic            beam_en
);
    import bp_pkg::*;

    beam_mode_e mode_e;
    logic       sync_rise;
    logic       view_beam;
    logic       tune_beam;
    logic       tune_busy;
    logic       pick;

    assign mode_e = beam_mode_e'(mode);

    bp_sync_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .sync_in (sync_in),
        .rise    (sync_rise)
    );

    bp_view_timer #(
        .CODE_W     (VL_W),
        .UNIT_TICKS (UNIT_TICKS)
    ) u_view (
        .clk   (clk),
        .rst   (rst),
        .abort (fault || (mode_e != BM_VIEW)),
        .start (sync_rise && (mode_e == BM_VIEW)),
        .code  (view_code),
        .beam  (view_beam)
    );

    bp_tune_seq #(
        .MK_W        (MK_W),
        .HEAD_TICKS  (HEAD_TICKS),
        .SPAN_TICKS  (SPAN_TICKS),
        .MARKER_BASE (MARKER_BASE),
        .FRAME_TICKS (FRAME_TICKS)
    ) u_tune (
        .clk       (clk),
        .rst       (rst),
        .abort     (fault || (mode_e != BM_TUNE)),
        .trigger   (sync_rise && (mode_e == BM_TUNE)),
        .mark_code (mark_code),
        .beam      (tune_beam),
        .busy      (tune_busy)
    );

    always_comb begin
        unique case (mode_e)
            BM_VIEW: pick = view_beam;
            BM_TUNE: pick = tune_beam;
            BM_CW:   pick = 1'b1;
            BM_PASS: pick = ext_gate;
            default: pick = 1'b0;
        endcase
    end

    assign beam_en = ~rst & ~fault & pick;
endmodule

// File: rtl/bp_checker.sv
module bp_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input logic       fault,
    input logic       gate,
    input logic       sync_rise,
    input logic       tune_busy,
    input logic       beam_en
);
    a_r9_fault_kills: assert property (@(posedge clk) disable iff (rst)
        fault |-> !beam_en);

    a_r7_cw_hold: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10 && !fault) |-> beam_en);

    a_r8_gate_follow: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11 && !fault) |-> (beam_en == gate));

    a_r2_view_needs_edge: assert property (@(posedge clk) disable iff (rst)
        ($rose(beam_en) && mode == 2'b00) |-> ($past(sync_rise) && $past(mode) == 2'b00));

    a_r4_tune_in_frame: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && beam_en) |-> tune_busy);
endmodule

bind beam_pattern_gen bp_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .fault     (fault),
    .gate      (ext_gate),
    .sync_rise (sync_rise),
    .tune_busy (tune_busy),
    .beam_en   (beam_en)
);

// File: tb/beam_pattern_gen_bench.sv
module beam_pattern_gen_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       sync_in;
    logic [1:0] mode;
    logic [5:0] view_code;
    logic [3:0] mark_code;
    logic       ext_gate;
    logic       fault;
    logic       beam_en;

    always #10 clk = ~clk;

    beam_pattern_gen u_beam_pattern_gen (
        .clk       (clk),
        .rst       (rst),
        .sync_in   (sync_in),
        .mode      (mode),
        .view_code (view_code),
        .mark_code (mark_code),
        .ext_gate  (ext_gate),
        .fault     (fault),
        .beam_en   (beam_en)
    );

    typedef struct {
        bit    exp;
        string tag;
    } item_t;

    item_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // Current stimulus
    bit       c_rst = 1, c_fault = 0, c_gate = 0;
    bit [1:0] c_mode = 2'b10;
    bit [5:0] c_code = 6'd1;
    bit [3:0] c_mk   = 4'd8;

    // Reference model state
    bit prev_sync = 0;
    int vl_left = 0;
    bit t_run = 0;
    int t_pos = 0;
    int t_mlen = 0;

    task automatic step(input bit s, input string tag);
        bit rise;
        bit e;
        item_t it;
        @(negedge clk);
        rst = c_rst; sync_in = s; mode = c_mode; view_code = c_code;
        mark_code = c_mk; ext_gate = c_gate; fault = c_fault;
        rise = s && !prev_sync;
        if (c_rst || c_fault) e = 0;
        else begin
            case (c_mode)
                2'b00: e = (vl_left > 0);
                2'b01: e = t_run && (t_pos < 2 || (t_pos >= 834 - t_mlen && t_pos < 834));
                2'b10: e = 1;
                default: e = c_gate;
            endcase
        end
        it.exp = e;
        it.tag = c_rst ? "R1" : (c_fault ? "R9" : tag);
        q.push_back(it);
        // model update for the coming edge
        prev_sync = c_rst ? 0 : s;
        if (c_rst || c_fault) begin
            vl_left = 0; t_run = 0; t_pos = 0;
        end else begin
            if (c_mode != 2'b00) vl_left = 0;
            else if (rise) vl_left = 2 * ((c_code == 0) ? 1 : int'(c_code));
            else if (vl_left > 0) vl_left--;
            if (c_mode != 2'b01) begin
                t_run = 0; t_pos = 0;
            end else if (t_run) begin
                if (t_pos == 2831) t_run = 0;
                else t_pos++;
            end else if (rise) begin
                t_run = 1; t_pos = 0; t_mlen = 44 - int'(c_mk);
            end
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, tag);
    endtask

    task automatic fire(input string tag);
        step(1, tag);
    endtask

    // Monitor: compare each predicted cycle
    initial begin
        forever begin
            @(negedge clk);
            #5;
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_cmp++;
                if (beam_en !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: beam_en actual=%0b expected=%0b at %0t",
                             it.tag, beam_en, it.exp, $time);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset holds output low even in CW mode
        c_rst = 1; c_mode = 2'b10;
        idle(4, "R1");
        c_rst = 0; c_mode = 2'b00;
        idle(3, "R1");

        // R2: viewer-limited pulses of several lengths
        c_code = 6'd1;  fire("R2"); idle(6, "R2");
        c_code = 6'd5;  fire("R2"); idle(14, "R2");
        c_code = 6'd63; fire("R2"); idle(130, "R2");
        // R3: code 0 behaves as code 1
        c_code = 6'd0;  fire("R3"); idle(8, "R3");
        // R2: retrigger restarts pulse
        c_code = 6'd10; fire("R2"); idle(8, "R2"); fire("R2"); idle(26, "R2");
        // R2: held sync gives a single pulse
        c_code = 6'd3;
        for (int i = 0; i < 20; i++) step(1, "R2");
        idle(10, "R2");

        // R4: default tune frame; R6: edge mid-frame ignored
        c_mode = 2'b01; c_mk = 4'd8;
        fire("R4"); idle(100, "R4"); fire("R6"); idle(2740, "R4");
        // R6: edge after the frame is accepted
        fire("R6"); idle(2835, "R6");
        // R5: extreme marker codes, code captured at start
        c_mk = 4'd0;  fire("R5"); idle(2835, "R5");
        c_mk = 4'd15; fire("R5"); idle(50, "R5");
        c_mk = 4'd3;  idle(2790, "R5");

        // R7: CW
        c_mode = 2'b10; idle(20, "R7");
        // R8: pass-through gate
        c_mode = 2'b11;
        for (int i = 0; i < 24; i++) begin
            c_gate = (i % 3) != 0;
            step(0, "R8");
        end
        // R9: fault in CW and pass modes
        c_gate = 1;
        c_fault = 1; idle(3, "R9"); c_fault = 0; idle(3, "R8");
        c_mode = 2'b10;
        c_fault = 1; idle(2, "R9"); c_fault = 0; idle(3, "R7");

        // R10: fault aborts viewer-limited pulse
        c_mode = 2'b00; c_code = 6'd20;
        idle(2, "R10"); fire("R10"); idle(5, "R10");
        c_fault = 1; idle(2, "R9"); c_fault = 0; idle(40, "R10");
        // R10: fault aborts tune frame inside marker
        c_mode = 2'b01; c_mk = 4'd8;
        fire("R10"); idle(810, "R10");
        c_fault = 1; idle(3, "R9"); c_fault = 0; idle(40, "R10");
        // R10: mode change aborts tune frame
        fire("R10"); idle(5, "R10");
        c_mode = 2'b10; idle(3, "R7");
        c_mode = 2'b01; idle(900, "R10");
        fire("R10"); idle(10, "R4");

        idle(2, "R10");
        @(negedge clk); #8;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule